// File: doc/BRIEF.md
# Clock Loss-of-Signal Monitor

This block decides whether a monitored clock is alive. It needs no timing information from that clock. All of its timers run on a free-running reference clock. Each rising edge of the monitored clock flips a toggle bit in the monitored domain. A synchroniser carries that bit into the reference domain, where any change in it counts as one observed edge.

The single status output, `lossFlag`, reads high while the clock is considered lost and low while it is considered present. The flag rises only after the monitored clock has been silent for a long window. It falls again only after edges have arrived steadily for a much shorter qualification window. It can never fall before a start-up period measured from reset has ended.

All time constants are parameters in reference-clock cycles. Silicon builds set them to second-scale and millisecond-scale values. Simulation shrinks them to a few dozen cycles.

Top module: `clk_loss_monitor`

## Requirements
- R1: `lossFlag` is 1 while `rstN` is low, taking effect without waiting for a clock edge, and it is still 1 on the first cycles after reset is released.
- R2: `lossFlag` stays 1 for at least `STARTUP_CYCLES` reference cycles after reset is released, even when the monitored clock runs cleanly from the start.
- R3: While `lossFlag` is 0, `LOSS_CYCLES` consecutive reference cycles with no observed edge make `lossFlag` rise. An edge is observed two synchroniser stages plus one compare stage after it happens.
- R4: While `lossFlag` is 0, any single observed edge restarts the silence count from zero.
- R5: From the lost state, `lossFlag` falls only after `CLEAR_CYCLES` reference cycles of qualification. Qualification starts at the first observed edge. During it, no run of `GAP_CYCLES` or more edge-free cycles may occur. Such a run returns the monitor to the lost state, and qualification then restarts at the next edge.
- R6: A monitored clock whose observed edges are spaced more than `GAP_CYCLES` reference cycles apart never clears `lossFlag`.
- R7: A single isolated edge while the clock is lost leaves `lossFlag` at 1.
- R8: The monitored-domain toggle is bit `DIV_LOG2-1` of a free-running counter of monitored edges. With `DIV_LOG2 = 1` every monitored rising edge produces one observed edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Free-running reference clock; all timers count its cycles |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| monClk | input | 1 | Monitored clock whose presence is being judged |
| lossFlag | output | 1 | 1 = monitored clock lost, 0 = monitored clock present |

## Verification
The hardest situation to reach is the boundary between a gap that breaks qualification and one that does not. The outcome depends on where the monitored edges fall relative to reference edges after synchronisation. The bench places every monitored edge on integer nanoseconds, while reference edges fall on half nanoseconds, so the bench knows exactly which reference edge captures each toggle. It then runs monitored periods just below and well above the gap limit. It also injects lone hand-made edges, one into a healthy clock just before the loss limit and one into a dead clock. A behavioural model that tracks edge age, qualification length and time since reset is compared with `lossFlag` on every cycle.

// File: rtl/clm_pkg.sv
`timescale 1ns/1ps
package clm_pkg;

  typedef enum logic [1:0] {
    ST_LOST    = 2'd0,
    ST_QUAL    = 2'd1,
    ST_PRESENT = 2'd2
  } monState_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic qualClr;
    logic qualRun;
  } ctrlStrobe_t;

  // conditions reported by the datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic gapHit;
    logic lossHit;
    logic qualDone;
  } dpStatus_t;

endpackage

// File: rtl/clm_edge_capture.sv
`timescale 1ns/1ps
module clm_edge_capture #(
  parameter int DIV_LOG2    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic monClk,
  input  logic refClk,
  input  logic rstN,
  output logic edgeSeen
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [DIV_LOG2-1:0] monDiv;
  logic                monToggle;
  logic [CHAIN_W-1:0]  syncChain;

  // monitored domain: divided toggle
  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) monDiv <= '0;
    else       monDiv <= monDiv + DIV_LOG2'(1);
  end
  assign monToggle = monDiv[DIV_LOG2-1];

  // reference domain: synchroniser plus one history stage
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[CHAIN_W-2:0], monToggle};
  end

  assign edgeSeen = syncChain[CHAIN_W-1] ^ syncChain[CHAIN_W-2];
endmodule

// File: rtl/clm_datapath.sv
`timescale 1ns/1ps
module clm_datapath
  import clm_pkg::*;
#(
  parameter int LOSS_CYCLES    = 100,
  parameter int CLEAR_CYCLES   = 30,
  parameter int STARTUP_CYCLES = 40,
  parameter int GAP_CYCLES     = 8,
  parameter int DIV_LOG2       = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        monClk,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);
  localparam int IDLE_W  = $clog2(LOSS_CYCLES + 1);
  localparam int QUAL_W  = $clog2(CLEAR_CYCLES + 1);
  localparam int START_W = $clog2(STARTUP_CYCLES + 1);
  localparam logic [IDLE_W-1:0]  IDLE_MAX  = IDLE_W'(LOSS_CYCLES);
  localparam logic [IDLE_W-1:0]  GAP_LIM   = IDLE_W'(GAP_CYCLES);
  localparam logic [QUAL_W-1:0]  QUAL_MAX  = QUAL_W'(CLEAR_CYCLES);
  localparam logic [START_W-1:0] START_MAX = START_W'(STARTUP_CYCLES);

  logic               edgeSeen;
  logic [IDLE_W-1:0]  idleCnt;
  logic [QUAL_W-1:0]  qualCnt;
  logic [START_W-1:0] startCnt;
  logic               startDone;

  clm_edge_capture #(
    .DIV_LOG2   (DIV_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_cap (
    .monClk  (monClk),
    .refClk  (refClk),
    .rstN    (rstN),
    .edgeSeen(edgeSeen)
  );

  // cycles since the last observed edge, saturating at the loss limit
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 idleCnt <= '0;
    else if (edgeSeen)         idleCnt <= '0;
    else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + IDLE_W'(1);
  end

  // length of the current qualification run
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 qualCnt <= '0;
    else if (strobe.qualClr)   qualCnt <= '0;
    else if (strobe.qualRun && qualCnt != QUAL_MAX) qualCnt <= qualCnt + QUAL_W'(1);
  end

  // start-up timer, counts once after reset
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                    startCnt <= '0;
    else if (startCnt != START_MAX) startCnt <= startCnt + START_W'(1);
  end

  assign startDone       = (startCnt == START_MAX);
  assign status.edgeSeen = edgeSeen;
  assign status.gapHit   = !edgeSeen && (idleCnt >= GAP_LIM);
  assign status.lossHit  = !edgeSeen && (idleCnt == IDLE_MAX);
  assign status.qualDone = (qualCnt == QUAL_MAX) && startDone;
endmodule

// File: rtl/clm_control.sv
`timescale 1ns/1ps
module clm_control
  import clm_pkg::*;
(
  input  logic        refClk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        lossFlag
);
  monState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOST:    if (status.edgeSeen) stateNext = ST_QUAL;
      ST_QUAL: begin
        if (status.gapHit)        stateNext = ST_LOST;
        else if (status.qualDone) stateNext = ST_PRESENT;
      end
      ST_PRESENT: if (status.lossHit) stateNext = ST_LOST;
      default:    stateNext = ST_LOST;
    endcase
  end

  always_comb begin
    strobe.qualRun = (state == ST_QUAL);
    strobe.qualClr = (state != ST_QUAL) || status.gapHit;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LOST;
      lossFlag <= 1'b1;
    end else begin
      state    <= stateNext;
      lossFlag <= (stateNext != ST_PRESENT);
    end
  end
endmodule

// File: rtl/clk_loss_monitor.sv
`timescale 1ns/1ps
module clk_loss_monitor
  import clm_pkg::*;
#(
  parameter int LOSS_CYCLES    = 26_000_000,
  parameter int CLEAR_CYCLES   = 2_000_000,
  parameter int STARTUP_CYCLES = 20_000,
  parameter int GAP_CYCLES     = 16,
  parameter int DIV_LOG2       = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic monClk,
  output logic lossFlag
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  clm_datapath #(
    .LOSS_CYCLES   (LOSS_CYCLES),
    .CLEAR_CYCLES  (CLEAR_CYCLES),
    .STARTUP_CYCLES(STARTUP_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES),
    .DIV_LOG2      (DIV_LOG2),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .refClk(refClk),
    .rstN  (rstN),
    .monClk(monClk),
    .strobe(strobe),
    .status(status)
  );

  clm_control u_ctl (
    .refClk  (refClk),
    .rstN    (rstN),
    .status  (status),
    .strobe  (strobe),
    .lossFlag(lossFlag)
  );
endmodule

// File: rtl/clm_checker.sv
`timescale 1ns/1ps
module clm_checker
  import clm_pkg::*;
#(
  parameter int STARTUP_CYCLES = 40
) (
  input logic      refClk,
  input logic      rstN,
  input logic      lossFlag,
  input dpStatus_t status
);
  int unsigned sinceRst;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) sinceRst <= 0;
    else if (sinceRst < STARTUP_CYCLES) sinceRst <= sinceRst + 1;
  end

  AST_STARTUP_HOLD: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst < STARTUP_CYCLES) |-> lossFlag); // R2

  AST_LOSS_DECLARE: assert property (@(posedge refClk) disable iff (!rstN)
    (status.lossHit && !lossFlag) |=> lossFlag); // R3

  AST_RISE_NEEDS_SILENCE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lossFlag) |-> $past(status.lossHit)); // R3

  AST_EDGE_RESTARTS: assert property (@(posedge refClk) disable iff (!rstN)
    status.edgeSeen |=> !status.lossHit); // R4

  AST_CLEAR_QUALIFIED: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lossFlag) |-> $past(status.qualDone)); // R5

  AST_GAP_KEEPS_LOST: assert property (@(posedge refClk) disable iff (!rstN)
    (status.gapHit && lossFlag) |=> lossFlag); // R6
endmodule

bind clk_loss_monitor clm_checker #(
  .STARTUP_CYCLES(STARTUP_CYCLES)
) u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .lossFlag(lossFlag),
  .status  (status)
);

// File: tb/clk_loss_monitor_tb.sv
`timescale 1ns/1ps
module clk_loss_monitor_tb;
  localparam int LOSS    = 100;
  localparam int CLEAR   = 30;
  localparam int STARTUP = 40;
  localparam int GAP     = 8;

  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic monClk = 1'b0;
  logic lossFlag;

  int monHalf = 3;
  bit monEn   = 1'b0;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  clk_loss_monitor #(
    .LOSS_CYCLES   (LOSS),
    .CLEAR_CYCLES  (CLEAR),
    .STARTUP_CYCLES(STARTUP),
    .GAP_CYCLES    (GAP),
    .DIV_LOG2      (1),
    .SYNC_STAGES   (2)
  ) u_dut (
    .refClk  (refClk),
    .rstN    (rstN),
    .monClk  (monClk),
    .lossFlag(lossFlag)
  );

  // 200 MHz reference; rising edges on half nanoseconds
  always #2.5 refClk = ~refClk;

  // monitored clock; every change lands on an integer nanosecond
  initial forever begin
    #(monHalf);
    if (monEn) monClk = ~monClk;
  end

  // stimulus bookkeeping: number of monitored rising edges (R8, DIV_LOG2 = 1)
  int monCnt;
  always @(posedge monClk or negedge rstN) begin
    if (!rstN) monCnt <= 0;
    else       monCnt <= monCnt + 1;
  end

  // behavioural reference model
  int s1, s2, s3, edgeAge, runLen, upTime, phase;
  bit e, gapBrk, silent, ready;
  int nphase;
  always @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      s1 = 0; s2 = 0; s3 = 0; edgeAge = 0; runLen = 0; upTime = 0; phase = 0;
    end else begin
      e      = (s2 != s3);
      gapBrk = !e && (edgeAge >= GAP);
      silent = !e && (edgeAge == LOSS);
      ready  = (runLen >= CLEAR) && (upTime >= STARTUP);
      nphase = phase;
      if (phase == 0 && e) nphase = 1;
      else if (phase == 1 && gapBrk) nphase = 0;
      else if (phase == 1 && ready) nphase = 2;
      else if (phase == 2 && silent) nphase = 0;
      if (phase == 1 && !gapBrk) runLen = (runLen < CLEAR) ? runLen + 1 : runLen;
      else runLen = 0;
      edgeAge = e ? 0 : ((edgeAge < LOSS) ? edgeAge + 1 : edgeAge);
      upTime  = (upTime < STARTUP) ? upTime + 1 : upTime;
      phase = nphase;
      s3 = s2; s2 = s1; s1 = monCnt & 1;
    end
  end

  // lockstep comparison every cycle (R1 flag meaning)
  always @(negedge refClk) begin
    vectors++;
    if (lossFlag !== (phase != 2)) begin
      miscompares++;
      $display("FAIL R1 lockstep: lossFlag=%0b expected %0b at %0t", lossFlag, (phase != 2), $time);
    end
  end

  task automatic chk(input string req, input logic expv);
    vectors++;
    if (lossFlag !== expv) begin
      miscompares++;
      $display("FAIL %s: lossFlag=%0b expected %0b at %0t", req, lossFlag, expv, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic onePulse();
    monClk = 1'b0;
    #1 monClk = 1'b1;
    #2 monClk = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge refClk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, 100000);
      finishRun();
    end
  end

  initial begin
    waitCyc(3);
    chk("R1 flag high in reset", 1'b1);
    monHalf = 3; monEn = 1'b1;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
    chk("R1 flag high after reset", 1'b1);
    waitCyc(35);
    chk("R2 held by start-up timer", 1'b1);
    waitCyc(14);
    chk("R2 released after start-up", 1'b0);

    // clock stops
    monEn = 1'b0;
    waitCyc(90);
    chk("R3 still present before loss window", 1'b0);
    waitCyc(25);
    chk("R3 loss declared", 1'b1);

    // medium clock, edge spacing below gap limit
    monHalf = 15; monEn = 1'b1;
    waitCyc(20);
    chk("R5 not cleared before qualification", 1'b1);
    waitCyc(40);
    chk("R5 cleared after qualification", 1'b0);

    // isolated edge restarts the loss timer
    monEn = 1'b0;
    waitCyc(60);
    onePulse();
    waitCyc(60);
    chk("R4 single edge restarted timer", 1'b0);
    waitCyc(60);
    chk("R4 loss after restarted window", 1'b1);

    // isolated edge while lost
    onePulse();
    waitCyc(60);
    chk("R7 isolated edge keeps lost", 1'b1);

    // slow clock, edge spacing above gap limit
    monHalf = 30; monEn = 1'b1;
    waitCyc(300);
    chk("R6 sparse edges never clear", 1'b1);

    // fast clock returns (R8 every monitored edge observed)
    monHalf = 3;
    waitCyc(60);
    chk("R8 fast clock clears", 1'b0);

    // asynchronous reset in the present state
    rstN = 1'b0;
    #1;
    chk("R1 async reset raises flag", 1'b1);
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(36);
    chk("R2 start-up hold after second reset", 1'b1);
    waitCyc(14);
    chk("R2 clears after second start-up", 1'b0);

    finishRun();
  end
endmodule